// File: doc/BRIEF.md
# Interrupt Request Latch with Per-Line Trigger Mode

This block turns eight raw interrupt request inputs into a register of pending requests. Each line first passes through a two-flop synchronizer. A per-line trigger-mode register then decides how the line is handled. A line in edge mode latches a pending request on a low-to-high transition, and the request stays pending until the line is acknowledged. A line in level mode has a pending bit that simply tracks the synchronized input. For every line the block records the last sampled level, so that it can detect the next rising transition.

Software reaches the trigger-mode register through a byte-wide bus port. Writes and reads are decoded at one configurable address. A fixed mask parameter picks which bits are writable, and the locked lines always stay in edge mode. Two instances cover the usual system: the primary uses mask 0xF8 at 0x4D0, and the secondary uses 0xDE at 0x4D1. A write to the command base address with bit 4 set is an initialization command. It clears the trigger modes, the pending bits and the recorded levels, and it captures bit 0 of the written byte as a flag meaning that a fourth initialization word follows. The acknowledge input lets downstream priority logic retire an edge-mode request.

Top module: `irqTrigLatch`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level mode) has its pending bit set while its synchronized input is high and cleared while it is low, acknowledge notwithstanding.
- R2: A line whose trigger-mode bit is 0 (edge mode) gets its pending bit set only when the synchronized input is high and the recorded previous level is low. A low input never clears it.
- R3: The recorded previous level of every line follows the synchronized input on every clock, in both modes. A line held high after acknowledge therefore does not set its pending bit again, and a new rising transition does set it.
- R4: A bus write with busAddr equal to ELCR_ADDR stores busWrData AND WR_MASK into the trigger-mode register. busRdData returns the stored value combinationally while busAddr equals ELCR_ADDR.
- R5: Lines whose WR_MASK bit is 0 can never be put into level mode. With the default mask 0xF8, lines 0 to 2 stay in edge mode, so writing 0xFF reads back 0xF8.
- R6: Writes to any other address leave the trigger-mode register unchanged, and busRdData is 0 when busAddr differs from ELCR_ADDR. A write to CMD_BASE with bit 4 clear causes no initialization.
- R7: A write to CMD_BASE with bit 4 set clears the trigger-mode register, all pending bits and all previous levels on that clock, and loads icw4Pending from bit 0 of busWrData. WR_MASK still applies afterwards.
- R8: ackLine (one-hot) clears the pending bit of an acknowledged edge-mode line on the next clock. It has no effect on level-mode lines.
- R9: If a rising transition on an edge-mode line and its acknowledge arrive on the same clock, the line's pending bit ends set.
- R10: Reset (rstN low) drives the trigger-mode register, the pending bits, the previous levels and icw4Pending to 0.
- R11: A change on irqIn reaches irrOut on the third rising clock edge after it is applied (two synchronizer stages plus the pending register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| irqIn | input | LINES | Raw interrupt request lines |
| ackLine | input | LINES | One-hot acknowledge of a pending line |
| busAddr | input | ADDR_W | Bus address for read and write |
| busWrEn | input | 1 | Bus write strobe, one cycle per write |
| busWrData | input | LINES | Bus write data |
| busRdData | output | LINES | Trigger-mode register readback |
| irrOut | output | LINES | Pending request bits |
| icw4Pending | output | 1 | Fourth-initialization-word flag captured at initialization |

## Verification
On an edge-mode line, acknowledge and a new rising transition can land on the same clock edge, and each one tries to move the pending bit in a different direction. The bench raises line 4 and applies its acknowledge exactly two steps later, so that the acknowledge is active on the edge where the synchronized rise reaches the pending register. It then expects the bit set. A level-mode line acknowledged while its input is high is also checked: it must stay pending. A third overlap is initialization while a line is held high. The bench expects the pending bit cleared on the initialization edge and set again one clock later, because the recorded level was cleared as well.

// File: rtl/irqTrigLatchPkg.sv
package irqTrigLatchPkg;

  // Strobes from the bus decode to the datapath
  typedef struct packed {
    logic       modeWr;   // store new trigger-mode value
    logic       initCmd;  // initialization command seen
    logic [7:0] wrByte;   // write data as presented
  } ctrlStrobes_t;

  localparam int INIT_BIT = 4;
  localparam int ICW4_BIT = 0;

endpackage

// File: rtl/irqLineCell.sv
module irqLineCell (
  input  logic clk,
  input  logic rstN,
  input  logic syncIn,
  input  logic levelMode,
  input  logic ackHit,
  input  logic initClr,
  output logic irrBit,
  output logic prevBit
);

  logic risePulse;
  assign risePulse = syncIn && !prevBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrBit  <= 1'b0;
      prevBit <= 1'b0;
    end else if (initClr) begin
      irrBit  <= 1'b0;
      prevBit <= 1'b0;
    end else begin
      prevBit <= syncIn;
      if (levelMode)
        irrBit <= syncIn;
      else if (risePulse)
        irrBit <= 1'b1;
      else if (ackHit)
        irrBit <= 1'b0;
    end
  end

  // R1
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelMode && !initClr) |=> (irrBit == $past(syncIn)));

  // R2
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!levelMode && !initClr && !ackHit && irrBit) |=> irrBit);

  // R8
  edge_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!levelMode && !initClr && ackHit && !(syncIn && !prevBit)) |=> !irrBit);

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!levelMode && !initClr && syncIn && !prevBit) |=> irrBit);

endmodule

// File: rtl/irqTrigCtrl.sv
module irqTrigCtrl
  import irqTrigLatchPkg::*;
#(
  parameter int          LINES     = 8,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] ELCR_ADDR = 16'h04D0,
  parameter logic [15:0] CMD_BASE  = 16'h0020
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [LINES-1:0]  busWrData,
  input  logic [LINES-1:0]  modeQ,
  output ctrlStrobes_t      strobes,
  output logic [LINES-1:0]  busRdData
);

  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(ELCR_ADDR);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_BASE);

  logic hitMode;
  logic hitCmd;

  assign hitMode = (busAddr == MODE_A);
  assign hitCmd  = (busAddr == CMD_A);

  always_comb begin
    strobes         = '0;
    strobes.wrByte  = 8'(busWrData);
    strobes.modeWr  = busWrEn && hitMode;
    strobes.initCmd = busWrEn && hitCmd && busWrData[INIT_BIT];
  end

  assign busRdData = hitMode ? modeQ : '0;

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.modeWr && strobes.initCmd));

  // R6
  rd_off_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hitMode |-> (busRdData == '0));

endmodule

// File: rtl/irqTrigDatapath.sv
module irqTrigDatapath
  import irqTrigLatchPkg::*;
#(
  parameter int         LINES   = 8,
  parameter logic [7:0] WR_MASK = 8'hF8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  logic [LINES-1:0] ackLine,
  input  ctrlStrobes_t     strobes,
  output logic [LINES-1:0] modeQ,
  output logic [LINES-1:0] irrOut,
  output logic             icw4Pending
);

  localparam logic [LINES-1:0] MASK_L = LINES'(WR_MASK);

  logic [LINES-1:0] syncA;
  logic [LINES-1:0] syncB;
  logic [LINES-1:0] prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ       <= '0;
      icw4Pending <= 1'b0;
    end else if (strobes.initCmd) begin
      modeQ       <= '0;
      icw4Pending <= strobes.wrByte[ICW4_BIT];
    end else if (strobes.modeWr) begin
      modeQ <= LINES'(strobes.wrByte) & MASK_L;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    irqLineCell u_cell (
      .clk      (clk),
      .rstN     (rstN),
      .syncIn   (syncB[i]),
      .levelMode(modeQ[i]),
      .ackHit   (ackLine[i]),
      .initClr  (strobes.initCmd),
      .irrBit   (irrOut[i]),
      .prevBit  (prevLvl[i])
    );
  end

  // R5
  locked_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ & ~MASK_L) == '0);

  // R7
  init_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.initCmd |=> (modeQ == '0 && irrOut == '0 && prevLvl == '0));

  // R3
  prev_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.initCmd && $past(!strobes.initCmd)) |-> (prevLvl == $past(syncB)));

endmodule

// File: rtl/irqTrigLatch.sv
module irqTrigLatch
  import irqTrigLatchPkg::*;
#(
  parameter int          LINES     = 8,
  parameter int          ADDR_W    = 16,
  parameter logic [7:0]  WR_MASK   = 8'hF8,
  parameter logic [15:0] ELCR_ADDR = 16'h04D0,
  parameter logic [15:0] CMD_BASE  = 16'h0020
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  irqIn,
  input  logic [LINES-1:0]  ackLine,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [LINES-1:0]  busWrData,
  output logic [LINES-1:0]  busRdData,
  output logic [LINES-1:0]  irrOut,
  output logic              icw4Pending
);

  ctrlStrobes_t     strobes;
  logic [LINES-1:0] modeQ;

  irqTrigCtrl #(
    .LINES    (LINES),
    .ADDR_W   (ADDR_W),
    .ELCR_ADDR(ELCR_ADDR),
    .CMD_BASE (CMD_BASE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .modeQ    (modeQ),
    .strobes  (strobes),
    .busRdData(busRdData)
  );

  irqTrigDatapath #(
    .LINES  (LINES),
    .WR_MASK(WR_MASK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .irqIn      (irqIn),
    .ackLine    (ackLine),
    .strobes    (strobes),
    .modeQ      (modeQ),
    .irrOut     (irrOut),
    .icw4Pending(icw4Pending)
  );

endmodule

// File: tb/irqTrigLatch_tb.sv
`timescale 1ns/1ps
module irqTrigLatch_tb;

  localparam logic [15:0] MODE_A = 16'h04D0;
  localparam logic [15:0] CMD_A  = 16'h0020;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  irqIn = '0;
  logic [7:0]  ackLine = '0;
  logic [15:0] busAddr = MODE_A;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [7:0]  irrOut;
  logic        icw4Pending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         kind;   // 0 irrOut, 1 busRdData, 2 icw4Pending
    logic [7:0] expVal;
    string      req;
  } expItem_t;

  expItem_t sbQ[$];

  always #4 clk = ~clk;

  irqTrigLatch u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ackLine(ackLine),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irrOut(irrOut), .icw4Pending(icw4Pending)
  );

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      expItem_t it;
      logic [7:0] act;
      wait (sbQ.size() != 0);
      it = sbQ.pop_front();
      case (it.kind)
        0:       act = irrOut;
        1:       act = busRdData;
        default: act = {7'b0, icw4Pending};
      endcase
      checks++;
      if (act !== it.expVal) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.expVal);
      end
    end
  end

  task automatic expectOut(int kind, logic [7:0] v, string req);
    expItem_t it;
    it.kind = kind; it.expVal = v; it.req = req;
    sbQ.push_back(it);
    wait (sbQ.size() == 0);
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic busWrite(logic [15:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    cyc(1);
    busWrEn = 1'b0; busAddr = MODE_A;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R10: reset state
    expectOut(0, 8'h00, "R10 irr");
    expectOut(1, 8'h00, "R10 mode");
    expectOut(2, 8'h00, "R10 icw4");
    rstN = 1'b1;
    cyc(1);

    // R4 R5: masked write
    busWrite(MODE_A, 8'hFF);
    expectOut(1, 8'hF8, "R5 mask F8");
    busWrite(MODE_A, 8'h0A);
    expectOut(1, 8'h08, "R4 stored masked");

    // R11 R2: edge line 0
    irqIn = 8'h01;
    cyc(2);
    expectOut(0, 8'h00, "R11 not yet");
    cyc(1);
    expectOut(0, 8'h01, "R2 edge set");
    irqIn = 8'h00;
    cyc(3);
    expectOut(0, 8'h01, "R2 low keeps");
    ackLine = 8'h01;
    cyc(1);
    ackLine = 8'h00;
    expectOut(0, 8'h00, "R8 edge ack");
    irqIn = 8'h01;
    cyc(3);
    expectOut(0, 8'h01, "R3 new rise");
    ackLine = 8'h01;
    cyc(1);
    ackLine = 8'h00;
    cyc(2);
    expectOut(0, 8'h00, "R3 held high no reset");

    // R1 R8: level line 3
    irqIn = 8'h09;
    cyc(3);
    expectOut(0, 8'h08, "R1 level set");
    ackLine = 8'h08;
    cyc(1);
    ackLine = 8'h00;
    expectOut(0, 8'h08, "R8 level ignores ack");
    irqIn = 8'h01;
    cyc(3);
    expectOut(0, 8'h00, "R1 level clear");

    // R5: locked line 1 behaves as edge
    irqIn = 8'h03;
    cyc(3);
    expectOut(0, 8'h02, "R5 line1 set");
    irqIn = 8'h01;
    cyc(3);
    expectOut(0, 8'h02, "R5 line1 edge hold");

    // R9: rise and ack on the same edge, line 4
    irqIn = 8'h11;
    cyc(2);
    ackLine = 8'h10;
    cyc(1);
    ackLine = 8'h00;
    expectOut(0, 8'h12, "R9 edge beats ack");
    irqIn = 8'h01;
    cyc(3);
    expectOut(0, 8'h12, "R9 stays");

    // R6: decode
    busWrite(MODE_A + 16'd2, 8'hFF);
    expectOut(1, 8'h08, "R6 other addr write");
    busAddr = MODE_A + 16'd2;
    #1;
    expectOut(1, 8'h00, "R6 rd off addr");
    busAddr = MODE_A;
    #1;
    busWrite(CMD_A, 8'h01);
    expectOut(1, 8'h08, "R6 cmd no init mode");
    expectOut(2, 8'h00, "R6 cmd no init icw4");
    expectOut(0, 8'h12, "R6 cmd no init irr");

    // R7: initialization with line 0 held high
    busWrite(CMD_A, 8'h11);
    expectOut(0, 8'h00, "R7 irr cleared");
    expectOut(2, 8'h01, "R7 icw4 captured");
    expectOut(1, 8'h00, "R7 mode cleared");
    cyc(1);
    expectOut(0, 8'h01, "R7 prev cleared");
    busWrite(MODE_A, 8'hFF);
    expectOut(1, 8'hF8, "R7 mask kept");
    busWrite(CMD_A, 8'h10);
    expectOut(2, 8'h00, "R7 icw4 zero");

    cyc(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule